// File: doc/BRIEF.md
# Serial Memory Target Front End with Pause Control

This block is the serial front end of a memory device that answers a host over a four-wire serial bus in clock mode 0. It samples chip select, serial clock, serial input and the pause pin through a synchronizer on the device's own system clock. It then assembles bytes MSB first from the serial input and hands each completed byte to the rest of the device with a one-cycle strobe. For test purposes the response path echoes: while byte n of a selection is being clocked in, the serial output carries byte n-1 of the same selection, MSB first.

The pause pin lets the host freeze a transfer without deselecting the device. A pause may begin or end only while the serial clock is low. While paused, the output driver is released, clock and data input are ignored, and the bit position is kept, so the transfer picks up at the exact bit where it stopped. If the host deselects during a pause, the interface drops the partial byte and reports a one-cycle reset event. It then stays silent until the pause pin is high and a fresh selection begins. When the quad-enable input is 1, the pause pin carries no control meaning and is ignored by this block. The pause affects only the serial traffic. Internal operations of the device are not touched.

Top module: `spi_hold_target`

## Requirements
- R1: After a synchronous reset, `so_oe`, `paused`, `rx_valid` and `if_reset` are all 0.
- R2: With chip select low, SI is sampled on each SCLK rising edge, MSB first. After every eighth rising edge of a selection, the byte appears on `rx_byte` together with a `rx_valid` pulse one system clock long.
- R3: `so_oe` is 1 while the device is selected and not paused. SO changes after SCLK falling edges. During the first byte of a selection SO is 0, and during byte n (n >= 1) it carries byte n-1, MSB first.
- R4: With `qe` = 0, a falling edge of HOLD_N while selected and with SCLK low starts a pause: `paused` goes to 1 and `so_oe` to 0.
- R5: If HOLD_N falls while SCLK is high, the pause starts only once SCLK has gone low.
- R6: A pause ends when HOLD_N is high and SCLK is low. If HOLD_N rises while SCLK is high, `paused` stays 1 until SCLK goes low.
- R7: While paused, SCLK and SI edges are ignored. No byte completes, and the bit count and shift contents survive, so the byte in progress completes correctly after the pause.
- R8: With `qe` = 1, HOLD_N is ignored: `paused` stays 0 and transfers continue whatever its level.
- R9: Raising chip select during a pause gives one `if_reset` pulse and discards the partial byte. The interface then stays inactive (`so_oe` = 0) until HOLD_N is high and a new chip select falling edge occurs. A selection that begins while HOLD_N is low is ignored.
- R10: Raising chip select outside a pause discards any partial byte without an `if_reset` pulse. The next selection starts at bit 0, with SO at 0 during its first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, mode 0 |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause request, active low, used only when `qe` = 0 |
| qe | input | 1 | Quad enable: 1 turns off pause handling |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the SO pad driver |
| paused | output | 1 | Serial state machine frozen by a pause |
| rx_byte | output | DW | Last received byte |
| rx_valid | output | 1 | One-cycle strobe per received byte |
| if_reset | output | 1 | One-cycle strobe when a pause is cut by deselection |

## Verification
Five properties are checked on every cycle:
- the output driver is off while paused;
- a pause never begins while quad enable is set;
- a reset event only ever follows a paused cycle;
- the received byte does not move during a pause;
- the byte strobe is never two cycles wide.

Some behaviours need the bench's scripted scenarios, because they depend on the order of pin events:
- deferred entry and exit while SCLK is high;
- resuming at the same bit after a pause with clock edges injected into it;
- the echo content of SO;
- the locked state after deselection during a pause, which needs both HOLD_N high and a new selection;
- the silent abort of a partial byte.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PAUSED = 2'd2,
    ST_LOCKED = 2'd3
  } if_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cs_n_s,
  input  logic      sclk_s,
  input  logic      hold_n_s,
  input  logic      qe,
  output logic      bit_rise,
  output logic      bit_fall,
  output logic      clr,
  output if_state_e st,
  output logic      rst_evt
);
  if_state_e nxt;
  logic cs_q, sclk_q, hold_q, ent_pend, evt_d;
  logic cs_fall, hold_fall;

  assign cs_fall   = cs_q & ~cs_n_s;
  assign hold_fall = hold_q & ~hold_n_s & ~qe;

  assign bit_rise = (st == ST_ACTIVE) && !cs_n_s && !sclk_q &&  sclk_s;
  assign bit_fall = (st == ST_ACTIVE) && !cs_n_s &&  sclk_q && !sclk_s;

  always_comb begin
    nxt   = st;
    clr   = 1'b0;
    evt_d = 1'b0;
    case (st)
      ST_IDLE: begin
        if (cs_fall) begin
          nxt = ST_ACTIVE;
          clr = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (cs_n_s) begin
          nxt = ST_IDLE;
          clr = 1'b1;
        end else if ((ent_pend || hold_fall) && !qe && !hold_n_s && !sclk_s) begin
          nxt = ST_PAUSED;
        end
      end
      ST_PAUSED: begin
        if (cs_n_s) begin
          nxt   = ST_LOCKED;
          clr   = 1'b1;
          evt_d = 1'b1;
        end else if (hold_n_s && !sclk_s) begin
          nxt = ST_ACTIVE;
        end
      end
      default: begin
        if (cs_fall && hold_n_s) begin
          nxt = ST_ACTIVE;
          clr = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      hold_q   <= 1'b1;
      ent_pend <= 1'b0;
      rst_evt  <= 1'b0;
    end else begin
      st      <= nxt;
      cs_q    <= cs_n_s;
      sclk_q  <= sclk_s;
      hold_q  <= hold_n_s;
      rst_evt <= evt_d;
      if (st != ST_ACTIVE || hold_n_s || qe || cs_n_s)
        ent_pend <= 1'b0;
      else if (hold_fall && sclk_s)
        ent_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          bit_rise,
  input  logic          bit_fall,
  input  logic          si_s,
  output logic [DW-1:0] rx_data,
  output logic          rx_strobe,
  output logic          so_bit
);
  localparam int          CW   = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] rx_sh, last_rx, tx_sh, rx_next;
  logic [CW-1:0] cnt;

  assign rx_next = {rx_sh[DW-2:0], si_s};
  assign so_bit  = tx_sh[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh     <= '0;
      last_rx   <= '0;
      tx_sh     <= '0;
      cnt       <= '0;
      rx_data   <= '0;
      rx_strobe <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      if (clr) begin
        rx_sh   <= '0;
        last_rx <= '0;
        tx_sh   <= '0;
        cnt     <= '0;
      end else begin
        if (bit_rise) begin
          rx_sh <= rx_next;
          if (cnt == LAST) begin
            cnt       <= '0;
            rx_data   <= rx_next;
            last_rx   <= rx_next;
            rx_strobe <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (bit_fall) begin
          if (cnt == '0) tx_sh <= last_rx;
          else           tx_sh <= {tx_sh[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_hold_target.sv
module spi_hold_target
  import spi_hold_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          si,
  input  logic          hold_n,
  input  logic          qe,
  output logic          so,
  output logic          so_oe,
  output logic          paused,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid,
  output logic          if_reset
);
  localparam int PINS = 4;

  logic [PINS-1:0] pins_s;
  logic            cs_n_s, hold_n_s, sclk_s, si_s;
  logic            bit_rise, bit_fall, clr;
  if_state_e       st;

  spi_pin_sync #(
    .W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)
  ) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, hold_n, sclk, si}),
    .q(pins_s)
  );

  assign {cs_n_s, hold_n_s, sclk_s, si_s} = pins_s;

  spi_hold_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cs_n_s(cs_n_s), .sclk_s(sclk_s), .hold_n_s(hold_n_s), .qe(qe),
    .bit_rise(bit_rise), .bit_fall(bit_fall), .clr(clr),
    .st(st), .rst_evt(if_reset)
  );

  spi_byte_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .clr(clr),
    .bit_rise(bit_rise), .bit_fall(bit_fall), .si_s(si_s),
    .rx_data(rx_byte), .rx_strobe(rx_valid), .so_bit(so)
  );

  assign so_oe  = (st == ST_ACTIVE);
  assign paused = (st == ST_PAUSED);
endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          qe,
  input logic          paused,
  input logic          so_oe,
  input logic [DW-1:0] rx_byte,
  input logic          rx_valid,
  input logic          if_reset
);
  // R4
  pause_releases_so_chk: assert property (@(posedge clk) disable iff (rst)
    paused |-> !so_oe);

  // R8
  qe_blocks_pause_chk: assert property (@(posedge clk) disable iff (rst)
    (qe && !paused) |=> !paused);

  // R9
  reset_after_pause_chk: assert property (@(posedge clk) disable iff (rst)
    if_reset |-> $past(paused));

  // R7
  byte_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    paused |=> $stable(rx_byte));

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

bind spi_hold_target spi_hold_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .qe(qe), .paused(paused), .so_oe(so_oe),
  .rx_byte(rx_byte), .rx_valid(rx_valid), .if_reset(if_reset)
);

// File: tb/tb_spi_hold_target.sv
`timescale 1ns/1ps
module tb_spi_hold_target;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst, cs_n, sclk, si, hold_n, qe;
  logic so, so_oe, paused, rx_valid, if_reset;
  logic [7:0] rx_byte;

  int n_chk = 0;
  int n_fail = 0;
  int rst_cnt = 0;
  bit done = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  spi_hold_target dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .si(si),
    .hold_n(hold_n), .qe(qe), .so(so), .so_oe(so_oe), .paused(paused),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .if_reset(if_reset)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_bit(input logic b, output logic s);
    si = b;
    wclk(H);
    s = so;
    sclk = 1'b1;
    wclk(H);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] exp_so, input string req);
    logic [7:0] got;
    exp_q.push_back(int'(tx));
    for (int i = 7; i >= 0; i--) do_bit(tx[i], got[i]);
    check(req, int'(got), int'(exp_so));
  endtask

  // reference bookkeeping: every received byte is compared against the queue
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (exp_q.size() == 0) check("R2 unexpected byte", int'(rx_byte), -1);
        else check("R2 rx_byte", int'(rx_byte), exp_q.pop_front());
      end
      if (if_reset) rst_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; si = 1'b0; hold_n = 1'b1; qe = 1'b0;
    wclk(5);
    rst = 1'b0;
    wclk(2);
    check("R1 so_oe", int'(so_oe), 0);
    check("R1 paused", int'(paused), 0);
    check("R1 rx_valid", int'(rx_valid), 0);
    check("R1 if_reset", int'(if_reset), 0);

    // plain transfers, echo pattern
    cs_n = 1'b0; wclk(H);
    check("R3 so_oe selected", int'(so_oe), 1);
    xfer(8'hA5, 8'h00, "R3 first byte SO");
    xfer(8'h3C, 8'hA5, "R3 echo 1");
    xfer(8'hFF, 8'h3C, "R3 echo 2");
    wclk(H); cs_n = 1'b1; wclk(H);
    check("R3 so_oe deselected", int'(so_oe), 0);

    // pause with SCLK low, junk clocks during pause
    cs_n = 1'b0; wclk(H);
    xfer(8'h12, 8'h00, "R3 first byte SO");
    exp_q.push_back(8'h5A);
    for (int i = 7; i >= 5; i--) do_bit(8'h5A >> i, got[i]);
    hold_n = 1'b0; wclk(H);
    check("R4 paused", int'(paused), 1);
    check("R4 so_oe off", int'(so_oe), 0);
    si = 1'b1;
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; wclk(H); sclk = 1'b0; wclk(H);
    end
    check("R7 still paused", int'(paused), 1);
    hold_n = 1'b1; wclk(H);
    check("R6 resumed", int'(paused), 0);
    check("R6 so_oe back", int'(so_oe), 1);
    for (int i = 4; i >= 0; i--) do_bit(8'h5A >> i, got[i]);
    check("R7 SO across pause", int'(got), 8'h12);
    wclk(H); cs_n = 1'b1; wclk(H);

    // deferred entry and exit with SCLK high
    cs_n = 1'b0; wclk(H);
    exp_q.push_back(8'h81);
    for (int i = 7; i >= 6; i--) do_bit(8'h81 >> i, got[i]);
    si = 1'b0; wclk(H); got[5] = so; sclk = 1'b1; wclk(H);
    hold_n = 1'b0; wclk(10);
    check("R5 no pause while SCLK high", int'(paused), 0);
    sclk = 1'b0; wclk(10);
    check("R5 pause after SCLK low", int'(paused), 1);
    sclk = 1'b1; wclk(H);
    hold_n = 1'b1; wclk(10);
    check("R6 exit waits for SCLK low", int'(paused), 1);
    sclk = 1'b0; wclk(10);
    check("R6 exit after SCLK low", int'(paused), 0);
    for (int i = 4; i >= 0; i--) do_bit(8'h81 >> i, got[i]);
    check("R3 SO first byte", int'(got), 0);
    xfer(8'hC3, 8'h81, "R7 echo after deferred pause");
    wclk(H); cs_n = 1'b1; wclk(H);

    // quad enable: HOLD_N ignored
    qe = 1'b1;
    cs_n = 1'b0; wclk(H);
    exp_q.push_back(8'h6E);
    for (int i = 7; i >= 4; i--) do_bit(8'h6E >> i, got[i]);
    hold_n = 1'b0; wclk(H);
    check("R8 no pause", int'(paused), 0);
    check("R8 so_oe kept", int'(so_oe), 1);
    for (int i = 3; i >= 0; i--) do_bit(8'h6E >> i, got[i]);
    wclk(H);
    check("R8 byte done", int'(exp_q.size()), 0);
    hold_n = 1'b1; cs_n = 1'b1; wclk(H);
    qe = 1'b0; wclk(H);

    // deselect during pause
    cs_n = 1'b0; wclk(H);
    for (int i = 7; i >= 5; i--) do_bit(1'b1, got[i]);
    hold_n = 1'b0; wclk(H);
    check("R9 paused", int'(paused), 1);
    cs_n = 1'b1; wclk(H);
    check("R9 one reset event", rst_cnt, 1);
    check("R9 so_oe off", int'(so_oe), 0);
    cs_n = 1'b0; wclk(H);
    check("R9 locked while HOLD low", int'(so_oe), 0);
    hold_n = 1'b1; wclk(H);
    check("R9 locked until new select", int'(so_oe), 0);
    cs_n = 1'b1; wclk(H); cs_n = 1'b0; wclk(H);
    check("R9 active after reselect", int'(so_oe), 1);
    xfer(8'h99, 8'h00, "R9 fresh byte SO");
    wclk(H); cs_n = 1'b1; wclk(H);

    // deselect outside a pause
    cs_n = 1'b0; wclk(H);
    for (int i = 7; i >= 3; i--) do_bit(1'b1, got[i]);
    cs_n = 1'b1; wclk(H);
    check("R10 no reset event", rst_cnt, 1);
    cs_n = 1'b0; wclk(H);
    xfer(8'h42, 8'h00, "R10 fresh byte SO");
    wclk(H); cs_n = 1'b1; wclk(H);

    check("R2 all bytes seen", int'(exp_q.size()), 0);
    check("R9 total reset events", rst_cnt, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule